// File: doc/BRIEF.md
# Shared Mode/Data Pin Arbiter

One input pin does two jobs. Held at a static level, it selects how both converter channels regulate: high means forced fixed-frequency PWM, and a long low means power-save. When it toggles, it carries a serial bit stream for a separate decoder. This block watches the synchronised pin level and produces the mode seen by every channel. It also produces a strobe that tells the bit decoder a bit period has begun.

A high level selects forced PWM in the same cycle it is seen. A falling edge does two things: it starts bit decoding and it arms a low-level timeout. Power-save is selected only when the pin stays low without a break for `TIMEOUT_CYC` clock cycles. A short low, such as a data bit, therefore never selects power-save. While the receiver reports a frame in progress, forced PWM is held and the timeout stays cleared, so protocol traffic cannot change the mode.

Top module: `mode_pin_arbiter`

## Requirements
- R1: Whenever `pin_level` is 1, every bit of `mode_ps` is 0 (forced PWM) in that same cycle, with no clock edge in between.
- R2: `decode_start` is 1 for exactly the one cycle in which `pin_level` is first seen 0 after having been 1 at the previous clock edge. It is 0 in every other cycle, including cycles where the pin rises.
- R3: After a falling edge, `mode_ps` stays 0 while fewer than `TIMEOUT_CYC` clock edges have sampled the pin low. It becomes all ones once `TIMEOUT_CYC` consecutive edges have sampled the pin low with `frame_active` at 0.
- R4: While `frame_active` is 1, `mode_ps` is 0 whatever the pin level. The low-time count restarts from zero, so after the flag drops with the pin still low, another `TIMEOUT_CYC` low edges are needed before power-save.
- R5: All `NUM_CH` bits of `mode_ps` always carry the same value: power-save is selected for all channels together.
- R6: Any cycle in which the pin is high clears the low-time count. Lows shorter than `TIMEOUT_CYC`, separated by highs of even one cycle, never select power-save.
- R7: Directly after reset, `mode_ps` is all ones if the pin is low and `frame_active` is 0, and `decode_start` is 0. A later high level is still needed before any falling edge is reported.
- R8: No start condition is needed when the line is already high. A falling edge after a high level of any length, even one cycle, produces `decode_start` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_level | input | 1 | Synchronised level of the shared mode/data pin |
| frame_active | input | 1 | From the receiver: a protocol frame is being received |
| mode_ps | output | NUM_CH | Per-channel mode: 1 selects power-save, 0 forced PWM |
| decode_start | output | 1 | One-cycle strobe marking the start of a bit period |

## Verification
The bench builds the arbiter with `TIMEOUT_CYC` = 12 and `NUM_CH` = 2. The short timeout lets it step through the exact cycle at which power-save is taken and the cycle just before it. It also makes trains of near-timeout lows separated by one-cycle highs cheap to run. Two channels are enough to show that the mode bits never disagree. With a frame flag held over several timeout periods, the bench can show that the count restarts only when the flag drops.

// File: rtl/mode_pin_arbiter.sv
module mode_pin_arbiter #(
  parameter int TIMEOUT_CYC = 26000,
  parameter int NUM_CH      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_level,
  input  logic              frame_active,
  output logic [NUM_CH-1:0] mode_ps,
  output logic              decode_start
);

  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic          pin_q;
  logic          ps_sel;
  logic [CW-1:0] low_cnt;
  logic          hold_pwm;

  assign hold_pwm     = pin_level | frame_active;
  assign decode_start = pin_q & ~pin_level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      ps_sel  <= 1'b1;
      low_cnt <= '0;
    end else begin
      pin_q <= pin_level;
      if (hold_pwm) begin
        ps_sel  <= 1'b0;
        low_cnt <= '0;
      end else if (!ps_sel) begin
        if (low_cnt == LAST) begin
          ps_sel  <= 1'b1;
          low_cnt <= '0;
        end else begin
          low_cnt <= low_cnt + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign mode_ps[g] = ps_sel & ~hold_pwm;
  end

endmodule

module mode_pin_arbiter_chk #(
  parameter int TIMEOUT_CYC = 26000,
  parameter int NUM_CH      = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pin_level,
  input logic              frame_active,
  input logic [NUM_CH-1:0] mode_ps,
  input logic              decode_start
);

  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  logic [CW-1:0] low_run;
  logic          broken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run <= '0;
      broken  <= 1'b0;
    end else if (pin_level || frame_active) begin
      low_run <= '0;
      broken  <= 1'b1;
    end else if (low_run != CW'(TIMEOUT_CYC)) begin
      low_run <= low_run + 1'b1;
    end
  end

  // R1
  pin_high_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_level |-> mode_ps == '0);

  // R4
  frame_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_active |-> mode_ps == '0);

  // R5
  same_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ps == '0 || mode_ps == '1);

  // R2
  strobe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decode_start |-> !pin_level && $past(pin_level));

  // R3 R6
  ps_needs_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ps[0] && broken) |-> low_run == CW'(TIMEOUT_CYC));

endmodule

bind mode_pin_arbiter mode_pin_arbiter_chk #(
  .TIMEOUT_CYC(TIMEOUT_CYC),
  .NUM_CH(NUM_CH)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .pin_level(pin_level),
  .frame_active(frame_active),
  .mode_ps(mode_ps),
  .decode_start(decode_start)
);

// File: tb/mode_pin_arbiter_bench.sv
module mode_pin_arbiter_bench;

  localparam int T  = 12;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pin_level = 1'b0;
  logic          frame_active = 1'b0;
  logic [NC-1:0] mode_ps;
  logic          decode_start;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit     chk;
    bit     ps;
    bit     strb;
    string  tag;
  } item_t;

  item_t q[$];

  always #5 clk = ~clk;

  mode_pin_arbiter #(.TIMEOUT_CYC(T), .NUM_CH(NC)) u_mode_pin_arbiter (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level),
    .frame_active(frame_active), .mode_ps(mode_ps),
    .decode_start(decode_start)
  );

  task automatic drive(input bit pin, input bit frm, input bit ps,
                       input bit strb, input string tag, input bit chk = 1'b1);
    item_t it;
    @(negedge clk);
    pin_level    = pin;
    frame_active = frm;
    it.chk = chk; it.ps = ps; it.strb = strb; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        logic [NC-1:0] exp_m;
        it = q.pop_front();
        exp_m = it.ps ? '1 : '0;
        if (it.chk) begin
          checks++;
          if (mode_ps !== exp_m || decode_start !== it.strb) begin
            errors++;
            $display("FAIL %s: mode_ps=%b decode_start=%b expected mode_ps=%b decode_start=%b",
                     it.tag, mode_ps, decode_start, exp_m, it.strb);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: power-save straight out of reset with pin low, no strobe
    drive(0, 0, 1, 0, "R7");
    drive(0, 0, 1, 0, "R7");
    // R1: high selects PWM in the same cycle; R2: no strobe on rise
    drive(1, 0, 0, 0, "R1");
    drive(1, 0, 0, 0, "R1");
    // R2 R3: fall strobes once, PS exactly after T low edges
    drive(0, 0, 0, 1, "R2");
    for (int j = 1; j < T; j++) drive(0, 0, 0, 0, "R3");
    drive(0, 0, 1, 0, "R3");
    drive(0, 0, 1, 0, "R3");
    // R8: one-cycle high then fall strobes immediately
    drive(1, 0, 0, 0, "R1");
    drive(0, 0, 0, 1, "R8");
    for (int j = 1; j < T - 1; j++) drive(0, 0, 0, 0, "R6", 1'b0);
    // R6: trains of T-1 lows split by one-cycle highs stay PWM
    for (int k = 0; k < 4; k++) begin
      drive(1, 0, 0, 0, "R6");
      drive(0, 0, 0, 1, "R6");
      for (int j = 1; j < T - 1; j++) drive(0, 0, 0, 0, "R6");
    end
    // last low of the train completes the run only after a full T
    drive(0, 0, 0, 0, "R6");
    drive(0, 0, 1, 0, "R3");
    // R4: frame holds PWM while pin toggles and while long low
    drive(1, 1, 0, 0, "R4");
    for (int k = 0; k < 3; k++) begin
      drive(0, 1, 0, 1, "R4");
      drive(1, 1, 0, 0, "R4");
    end
    drive(0, 1, 0, 1, "R4");
    for (int j = 0; j < 3 * T; j++) drive(0, 1, 0, 0, "R4");
    // R4: count restarts when the frame flag drops
    for (int j = 0; j < T; j++) drive(0, 0, 0, 0, "R4");
    drive(0, 0, 1, 0, "R4");
    // R5: every check above compares all channel bits against one value
    drive(1, 0, 0, 0, "R5");
    drive(0, 0, 0, 1, "R5");
    // R7: reset with pin high gives PWM and no strobe
    @(negedge clk);
    rst_n = 1'b0;
    pin_level = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(1, 0, 0, 0, "R7");
    drive(0, 0, 0, 1, "R2");
    repeat (3) @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    #5;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule